// File: doc/BRIEF.md
# Tower-Field AES Byte Substitution

This block computes the AES byte substitution or its inverse on one byte. The operation is chosen by a direction input.

In the forward direction the byte is inverted in GF(2^8) under the polynomial x^8+x^4+x^3+x+1, with zero taken to zero. The affine XOR map with constant 0x63 is then applied. In the inverse direction the inverse affine map, with constant 0x05, comes first and the inversion second.

The inversion does not use a 256-entry table. The byte is carried by a binary change-of-basis matrix into GF((2^2)^4), a degree-4 extension of GF(2^2) under y^4+y^3+y^2+ω. In that field the inverse comes from Cramer's rule on the 4x4 system over GF(2^2) that multiplication by the operand defines. A second matrix carries the result back. Both matrices are derived at elaboration from roots found by search, and both directions share the one inverter.

The result can be registered, which is the default, or taken straight from the logic.

Top module: `sbox_tower`

## Requirements
- R1: With `dir_inv`=0, `dout` equals the affine map of the GF(2^8) inverse of `din` (x^254 under 0x11B), for all 256 inputs. For example, 0x01 gives 0x7C and 0x53 gives 0xED.
- R2: With `dir_inv`=1, `dout` equals the GF(2^8) inverse of the inverse-affine map of `din`, for all 256 inputs.
- R3: A forward input of 0x00 yields 0x63.
- R4: An inverse input of 0x63 yields 0x00.
- R5: Feeding a forward result back with `dir_inv`=1 returns the original byte, for every byte.
- R6: With `OUT_REG`=1, `dout` at each rising edge takes the result for the `din` and `dir_inv` sampled at that edge. The output therefore tracks an input that changes every cycle and holds steady while the input holds.
- R7: While `rst_n` is low, `dout` is 0x00 whatever `din` and `dir_inv` are. This applies when `OUT_REG`=1.
- R8: No byte maps to itself in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| dir_inv | input | 1 | 0 selects forward substitution, 1 selects inverse |
| din | input | 8 | Byte to substitute |
| dout | output | 8 | Substituted byte |

## Verification
Zero is the input most likely to break: a tower inverter whose determinant is zero must give zero, or 0x00 forward would not give 0x63 and 0x63 inverse would not give 0x00. A wrong basis matrix or extension polynomial leaves some bytes right but corrupts many others, so every byte is compared in both directions against an inverse computed by exponentiation to 254. The round trip catches an affine map applied in the wrong order, which spoils only the inverse path. Alternating direction each cycle shows any latency slip or any select that lags the data.

// File: rtl/sbox_tower.sv
module sbox_tower #(
  parameter bit OUT_REG = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dir_inv,
  input  logic [7:0] din,
  output logic [7:0] dout
);

  function automatic logic [7:0] fmul(logic [7:0] a, logic [7:0] b);
    logic [7:0] p;
    logic [7:0] x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
    end
    return p;
  endfunction

  function automatic logic [7:0] mapv(logic [63:0] m, logic [7:0] v);
    logic [7:0] r;
    r = 8'h00;
    for (int n = 0; n < 8; n++)
      if (v[n]) r = r ^ m[8*n +: 8];
    return r;
  endfunction

  function automatic logic [63:0] build_to_poly();
    logic [7:0] w;
    logic [7:0] y;
    logic [7:0] yk;
    logic [7:0] c2;
    logic [7:0] c3;
    logic [7:0] c4;
    logic [63:0] m;
    w = 8'h00;
    y = 8'h00;
    m = '0;
    for (int c = 2; c < 256; c++)
      if (w == 8'h00 && (fmul(c[7:0], c[7:0]) ^ c[7:0]) == 8'h01) w = c[7:0];
    for (int c = 2; c < 256; c++) begin
      c2 = fmul(c[7:0], c[7:0]);
      c3 = fmul(c2, c[7:0]);
      c4 = fmul(c2, c2);
      if (y == 8'h00 && (c4 ^ c3 ^ c2 ^ w) == 8'h00) y = c[7:0];
    end
    yk = 8'h01;
    for (int k = 0; k < 4; k++) begin
      m[16*k +: 8]     = yk;
      m[16*k + 8 +: 8] = fmul(w, yk);
      yk = fmul(yk, y);
    end
    return m;
  endfunction

  function automatic logic [63:0] build_to_tower(logic [63:0] f);
    logic [63:0] m;
    m = '0;
    for (int k = 0; k < 8; k++)
      for (int t = 0; t < 256; t++)
        if (mapv(f, t[7:0]) == 8'(1 << k)) m[8*k +: 8] = t[7:0];
    return m;
  endfunction

  localparam logic [63:0] TO_POLY  = build_to_poly();
  localparam logic [63:0] TO_TOWER = build_to_tower(TO_POLY);

  function automatic logic [1:0] g4mul(logic [1:0] a, logic [1:0] b);
    return {(a[1] & b[1]) ^ (a[1] & b[0]) ^ (a[0] & b[1]),
            (a[1] & b[1]) ^ (a[0] & b[0])};
  endfunction

  function automatic logic [1:0] g4inv(logic [1:0] a);
    return {a[1], a[1] ^ a[0]};
  endfunction

  function automatic logic [1:0] g4w(logic [1:0] a);
    return {a[1] ^ a[0], a[1]};
  endfunction

  function automatic logic [7:0] times_y(logic [7:0] a);
    return {a[5:4] ^ a[7:6], a[3:2] ^ a[7:6], a[1:0], g4w(a[7:6])};
  endfunction

  function automatic logic [1:0] det3(logic [1:0] a, logic [1:0] b, logic [1:0] c,
                                      logic [1:0] d, logic [1:0] e, logic [1:0] f,
                                      logic [1:0] g, logic [1:0] h, logic [1:0] i);
    return g4mul(a, g4mul(e, i) ^ g4mul(f, h)) ^
           g4mul(b, g4mul(d, i) ^ g4mul(f, g)) ^
           g4mul(c, g4mul(d, h) ^ g4mul(e, g));
  endfunction

  function automatic logic [7:0] tower_inv(logic [7:0] a);
    logic [7:0] col [4];
    logic [1:0] mm  [4][4];
    logic [1:0] s   [3][3];
    logic [1:0] mn  [4];
    logic [1:0] dt;
    logic [1:0] di;
    logic [7:0] r;
    int idx;
    col[0] = a;
    for (int c = 1; c < 4; c++) col[c] = times_y(col[c-1]);
    for (int rr = 0; rr < 4; rr++)
      for (int c = 0; c < 4; c++) mm[rr][c] = col[c][2*rr +: 2];
    dt = 2'b00;
    for (int sk = 0; sk < 4; sk++) begin
      for (int rr = 1; rr < 4; rr++) begin
        idx = 0;
        for (int c = 0; c < 4; c++)
          if (c != sk) begin
            s[rr-1][idx] = mm[rr][c];
            idx++;
          end
      end
      mn[sk] = det3(s[0][0], s[0][1], s[0][2], s[1][0], s[1][1], s[1][2],
                    s[2][0], s[2][1], s[2][2]);
      dt = dt ^ g4mul(mm[0][sk], mn[sk]);
    end
    di = g4inv(dt);
    r = 8'h00;
    for (int k = 0; k < 4; k++) r[2*k +: 2] = g4mul(mn[k], di);
    return r;
  endfunction

  function automatic logic [7:0] rotl(logic [7:0] v, int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  logic [7:0] pre, inv_out, res;

  assign pre     = dir_inv ? (rotl(din, 1) ^ rotl(din, 3) ^ rotl(din, 6) ^ 8'h05) : din;
  assign inv_out = mapv(TO_POLY, tower_inv(mapv(TO_TOWER, pre)));
  assign res     = dir_inv ? inv_out
                           : (inv_out ^ rotl(inv_out, 1) ^ rotl(inv_out, 2) ^
                              rotl(inv_out, 3) ^ rotl(inv_out, 4) ^ 8'h63);

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) dout <= 8'h00;
      else        dout <= res;
  end else begin : g_comb
    assign dout = res;
  end

endmodule

module sbox_tower_chk #(
  parameter bit OUT_REG = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       dir_inv,
  input logic [7:0] din,
  input logic [7:0] dout
);

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;

  if (OUT_REG) begin : g_seq
    // R3
    fwd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir_inv && din == 8'h00) |=> dout == 8'h63);
    // R4
    inv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_inv && din == 8'h63) |=> dout == 8'h00);
    // R8
    no_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> dout != $past(din));
    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd2 && $stable(din) && $stable(dir_inv)) |=> $stable(dout));
  end else begin : g_cmb
    // R3
    fwd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir_inv && din == 8'h00) |-> dout == 8'h63);
    // R4
    inv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_inv && din == 8'h63) |-> dout == 8'h00);
    // R8
    no_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dout != din);
    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd2 && $stable(din) && $stable(dir_inv)) |-> $stable(dout));
  end

endmodule

bind sbox_tower sbox_tower_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .dir_inv(dir_inv), .din(din), .dout(dout)
);

// File: tb/sbox_tower_tb.sv
module sbox_tower_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dir_inv = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sbox_tower u_dut (.clk(clk), .rst_n(rst_n), .dir_inv(dir_inv), .din(din), .dout(dout));

  function automatic logic [7:0] gm(logic [7:0] a, logic [7:0] b);
    logic [7:0] p = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      p = {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
      if (b[i]) p = p ^ a;
    end
    return p;
  endfunction

  function automatic logic [7:0] pw254(logic [7:0] x);
    logic [7:0] r = 8'h01;
    for (int i = 0; i < 254; i++) r = gm(r, x);
    return r;
  endfunction

  function automatic logic [7:0] rl(logic [7:0] v, int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] ref_fwd(logic [7:0] x);
    logic [7:0] b = pw254(x);
    return b ^ rl(b, 1) ^ rl(b, 2) ^ rl(b, 3) ^ rl(b, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] ref_inv(logic [7:0] y);
    return pw254(rl(y, 1) ^ rl(y, 3) ^ rl(y, 6) ^ 8'h05);
  endfunction

  task automatic check(string req, logic [7:0] x, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s in=%02h got=%02h expected=%02h", req, x, got, exp);
    end
  endtask

  task automatic apply(logic d, logic [7:0] x, output logic [7:0] y);
    @(negedge clk);
    dir_inv = d;
    din = x;
    @(negedge clk);
    y = dout;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R7", din, dout, 8'h00);
    dir_inv = 1'b0;
    din = 8'h53;
    repeat (3) @(negedge clk);
    check("R7", din, dout, 8'h00);
    rst_n = 1'b1;
  endtask

  task automatic t_forward();
    logic [7:0] y;
    apply(1'b0, 8'h01, y); check("R1", 8'h01, y, 8'h7c);
    apply(1'b0, 8'h53, y); check("R1", 8'h53, y, 8'hed);
    for (int x = 0; x < 256; x++) begin
      apply(1'b0, x[7:0], y);
      check("R1", x[7:0], y, ref_fwd(x[7:0]));
      checks++;
      if (y == x[7:0]) begin
        fails++;
        $display("FAIL R8 fwd in=%02h got=%02h expected!=%02h", x[7:0], y, x[7:0]);
      end
    end
  endtask

  task automatic t_inverse();
    logic [7:0] y;
    for (int x = 0; x < 256; x++) begin
      apply(1'b1, x[7:0], y);
      check("R2", x[7:0], y, ref_inv(x[7:0]));
      checks++;
      if (y == x[7:0]) begin
        fails++;
        $display("FAIL R8 inv in=%02h got=%02h expected!=%02h", x[7:0], y, x[7:0]);
      end
    end
  endtask

  task automatic t_zero();
    logic [7:0] y;
    apply(1'b0, 8'h00, y); check("R3", 8'h00, y, 8'h63);
    apply(1'b1, 8'h63, y); check("R4", 8'h63, y, 8'h00);
  endtask

  task automatic t_roundtrip();
    logic [7:0] y;
    logic [7:0] z;
    for (int x = 0; x < 256; x++) begin
      apply(1'b0, x[7:0], y);
      apply(1'b1, y, z);
      check("R5", x[7:0], z, x[7:0]);
    end
  endtask

  task automatic t_pipeline();
    logic [7:0] seq [4] = '{8'h00, 8'hc3, 8'h63, 8'h9a};
    @(negedge clk);
    dir_inv = 1'b0;
    din = seq[0];
    for (int i = 1; i < 4; i++) begin
      @(negedge clk);
      check("R6", seq[i-1], dout, (i % 2 == 1) ? ref_fwd(seq[i-1]) : ref_inv(seq[i-1]));
      dir_inv = (i % 2 == 1);
      din = seq[i];
    end
    @(negedge clk);
    check("R6", seq[3], dout, ref_inv(seq[3]));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R6", seq[3], dout, ref_inv(seq[3]));
    end
  endtask

  task automatic t_midreset();
    logic [7:0] y;
    apply(1'b0, 8'h10, y);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R7", 8'h10, dout, 8'h00);
    @(negedge clk);
    check("R7", 8'h10, dout, 8'h00);
    rst_n = 1'b1;
    apply(1'b0, 8'h10, y);
    check("R1", 8'h10, y, ref_fwd(8'h10));
  endtask

  initial begin
    t_reset();
    t_zero();
    t_forward();
    t_inverse();
    t_roundtrip();
    t_pipeline();
    t_midreset();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog got=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule